// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a bank of maskable peripheral interrupt lines and a small group of non-maskable trap lines into one interrupt request for a processor core. With the request it presents the number of the winning vector and the 24-bit program address of that vector's table entry. The core fetches its handler address from that entry.

Each maskable source has an enable bit and a 3-bit priority. Arbitration ranks candidates by level first. Among candidates at the same level, the lower vector number wins. Traps always rank above maskable sources. A maskable winner is offered to the core only when its priority is strictly above the level the core is running at. A table-select input moves every vector address into an alternate table that has the same layout.

The core answers an offered request with an acknowledge. The block then clears the winner's pending flag and raises the running level to the winner's level. It pushes the old level onto a small stack, which a return strobe pops.

Top module: `pvic_top`

## Requirements
- R1: While reset is asserted and after it is released, int_req, vec_num, vec_addr and cur_level all read zero until a request arrives.
- R2: Trap line t maps to vector number t. Maskable line i maps to vector number N_TRAP+i.
- R3: vec_addr equals base + 2*vec_num. The base is 0x000004 when alt_sel is low. When alt_sel is high, the base is 0x000004 + 2*(N_TRAP+N_IRQ), which is 0x000100 with the default sizes.
- R4: A maskable source whose priority field is 0, or whose enable bit is low, never raises int_req. Its pending flag is kept, and it raises int_req once a nonzero priority and the enable are applied.
- R5: Among candidates, the highest level wins. Among equal levels, the lowest vector number wins.
- R6: Trap t has level 15-t, so it outranks every maskable source. A pending trap is offered whatever the value of cur_level.
- R7: A maskable winner is offered only if its priority is strictly greater than cur_level.
- R8: A request pulse sampled at one rising edge shows on the outputs at the next rising edge, and not earlier. This delay is the same for every source.
- R9: When ack is high while int_req is high, the block clears the offered vector's pending flag. On the next cycle int_req is low and cur_level equals the level of the offered vector.
- R10: A reti strobe restores the level saved by the most recent acknowledge. With nothing saved, it sets cur_level to 0.
- R11: A maskable line still high during its acknowledge sets its pending flag again and is offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | N_TRAP | Trap request lines, latched as pending |
| irq_req | input | N_IRQ | Maskable request lines, latched as pending |
| irq_en | input | N_IRQ | Per-source enable |
| irq_prio | input | 3*N_IRQ | Per-source priority, source i at bits [3i+2:3i] |
| alt_sel | input | 1 | Selects the alternate vector table |
| ack | input | 1 | Core accepts the offered vector |
| reti | input | 1 | Core returns from a handler |
| int_req | output | 1 | Interrupt request to the core |
| vec_num | output | 7 | Offered vector number |
| vec_addr | output | 24 | Program address of the offered vector entry |
| cur_level | output | 4 | Level the core currently runs at |

## Verification
The bench sends every source alone at every priority through both tables. It also sends every pair of sources together with priorities chosen so that ties occur. A design that broke ties toward the higher vector, or that got the alternate base wrong, would offer the wrong number or address in these sweeps. Equal-level requests are raised while a handler runs: a design that compared with greater-or-equal would nest them. The bench also stacks four acknowledges and then unwinds them, including one return too many. Broken stack handling would restore a wrong level or keep a stale one. A line that stays high across its acknowledge must be offered again, which catches a clear that beats the set.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int VEC_W  = 7;
  localparam int ADDR_W = 24;
  localparam int LVL_W  = 4;
  localparam int PRIO_W = 3;
  localparam logic [ADDR_W-1:0] PRIMARY_BASE = 24'h000004;

  // Base of the selected table: the alternate one follows the primary one.
  function automatic logic [ADDR_W-1:0] table_base(input logic alt, input int total);
    return alt ? PRIMARY_BASE + ADDR_W'(2 * total) : PRIMARY_BASE;
  endfunction

  // Each entry spans two program-address units.
  function automatic logic [ADDR_W-1:0] entry_addr(input logic alt, input logic [VEC_W-1:0] vec,
                                                   input int total);
    return table_base(alt, total) + {{(ADDR_W-VEC_W-1){1'b0}}, vec, 1'b0};
  endfunction

  // Fixed level of a trap: lower trap index ranks higher.
  function automatic logic [LVL_W-1:0] trap_level(input int t);
    return LVL_W'(15 - t);
  endfunction
endpackage

// File: rtl/pvic_pending.sv
module pvic_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  // A set in the same cycle as a clear wins, so held lines re-assert.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= (pend_o & ~clr_i) | set_i;
  end
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int N_TRAP = 8,
  parameter int N_IRQ  = 118
) (
  input  logic [N_TRAP-1:0]        trap_pend,
  input  logic [N_IRQ-1:0]         irq_pend,
  input  logic [N_IRQ-1:0]         irq_en,
  input  logic [N_IRQ*PRIO_W-1:0]  irq_prio,
  input  logic [LVL_W-1:0]         cur_level,
  output logic                     win_valid,
  output logic [VEC_W-1:0]         win_vec,
  output logic [LVL_W-1:0]         win_lvl
);
  localparam int TOTAL = N_TRAP + N_IRQ;

  logic [TOTAL-1:0] cand;
  logic [LVL_W-1:0] lvl [TOTAL];

  for (genvar t = 0; t < N_TRAP; t++) begin : g_trap
    assign lvl[t]  = trap_level(t);
    assign cand[t] = trap_pend[t];
  end

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    logic [PRIO_W-1:0] p;
    assign p              = irq_prio[i*PRIO_W +: PRIO_W];
    assign lvl[N_TRAP+i]  = {1'b0, p};
    assign cand[N_TRAP+i] = irq_pend[i] && irq_en[i] && (p != '0) && ({1'b0, p} > cur_level);
  end

  // Scan from the top down; ">=" lets a lower vector displace an equal level.
  always_comb begin
    win_valid = 1'b0;
    win_vec   = '0;
    win_lvl   = '0;
    for (int v = TOTAL - 1; v >= 0; v--) begin
      if (cand[v] && (!win_valid || lvl[v] >= win_lvl)) begin
        win_valid = 1'b1;
        win_vec   = VEC_W'(v);
        win_lvl   = lvl[v];
      end
    end
  end
endmodule

// File: rtl/pvic_level_stack.sv
module pvic_level_stack
  import pvic_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] cur_level
);
  localparam int SP_W  = $clog2(DEPTH + 1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVL_W-1:0] stk [DEPTH];
  logic [SP_W-1:0]  sp;
  logic [SP_W-1:0]  sp_m1;

  assign sp_m1 = sp - SP_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= '0;
      cur_level <= '0;
      for (int k = 0; k < DEPTH; k++) stk[k] <= '0;
    end else if (push) begin
      if (sp < SP_W'(DEPTH)) begin
        stk[sp[IDX_W-1:0]] <= cur_level;
        sp                 <= sp + SP_W'(1);
      end
      cur_level <= push_lvl;
    end else if (pop) begin
      if (sp != '0) begin
        cur_level <= stk[sp_m1[IDX_W-1:0]];
        sp        <= sp_m1;
      end else begin
        cur_level <= '0;
      end
    end
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int N_TRAP      = 8,
  parameter int N_IRQ       = 118,
  parameter int STACK_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_TRAP-1:0]       trap_req,
  input  logic [N_IRQ-1:0]        irq_req,
  input  logic [N_IRQ-1:0]        irq_en,
  input  logic [N_IRQ*3-1:0]      irq_prio,
  input  logic                    alt_sel,
  input  logic                    ack,
  input  logic                    reti,
  output logic                    int_req,
  output logic [6:0]              vec_num,
  output logic [23:0]             vec_addr,
  output logic [3:0]              cur_level
);
  localparam int TOTAL = N_TRAP + N_IRQ;

  logic [N_TRAP-1:0] trap_pend;
  logic [N_IRQ-1:0]  irq_pend;
  logic [TOTAL-1:0]  clr_vec;
  logic              take;
  logic              win_valid;
  logic [VEC_W-1:0]  win_vec;
  logic [LVL_W-1:0]  win_lvl;
  logic [LVL_W-1:0]  win_lvl_q;

  assign take = ack && int_req;

  for (genvar v = 0; v < TOTAL; v++) begin : g_clr
    assign clr_vec[v] = take && (vec_num == VEC_W'(v));
  end

  pvic_pending #(.N(N_TRAP)) u_trap_pend (
    .clk(clk), .rst_n(rst_n), .set_i(trap_req),
    .clr_i(clr_vec[N_TRAP-1:0]), .pend_o(trap_pend)
  );

  pvic_pending #(.N(N_IRQ)) u_irq_pend (
    .clk(clk), .rst_n(rst_n), .set_i(irq_req),
    .clr_i(clr_vec[TOTAL-1:N_TRAP]), .pend_o(irq_pend)
  );

  pvic_arbiter #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ)) u_arb (
    .trap_pend(trap_pend), .irq_pend(irq_pend), .irq_en(irq_en),
    .irq_prio(irq_prio), .cur_level(cur_level),
    .win_valid(win_valid), .win_vec(win_vec), .win_lvl(win_lvl)
  );

  pvic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(take), .push_lvl(win_lvl_q),
    .pop(reti), .cur_level(cur_level)
  );

  // Registered offer: same one-cycle stage for every source.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_req   <= 1'b0;
      vec_num   <= '0;
      vec_addr  <= '0;
      win_lvl_q <= '0;
    end else begin
      int_req   <= win_valid && !ack;
      vec_num   <= win_valid ? win_vec : '0;
      vec_addr  <= win_valid ? entry_addr(alt_sel, win_vec, TOTAL) : '0;
      win_lvl_q <= win_valid ? win_lvl : '0;
    end
  end
endmodule

// File: rtl/pvic_checker.sv
module pvic_checker #(
  parameter int N_TRAP = 8,
  parameter int N_IRQ  = 118
) (
  input logic        clk,
  input logic        rst_n,
  input logic        alt_sel,
  input logic        ack,
  input logic        reti,
  input logic        int_req,
  input logic [6:0]  vec_num,
  input logic [23:0] vec_addr,
  input logic [3:0]  cur_level,
  input logic [3:0]  win_lvl_q
);
  localparam int TOTAL = N_TRAP + N_IRQ;

  assert_vec_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int'(vec_num) < TOTAL));

  assert_table_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (int'(vec_addr) == ($past(alt_sel) ? 4 + 2 * TOTAL : 4) + 2 * int'(vec_num)));

  assert_trap_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int'(vec_num) < N_TRAP) |-> (int'(win_lvl_q) == 15 - int'(vec_num)));

  assert_mask_above_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && int'(vec_num) >= N_TRAP) |-> (win_lvl_q > $past(cur_level)));

  assert_ack_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !int_req);

  assert_ack_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_req) |=> (cur_level == $past(win_lvl_q)));

  assert_level_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && !reti) |=> $stable(cur_level));
endmodule

bind pvic_top pvic_checker #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .alt_sel(alt_sel), .ack(ack), .reti(reti),
  .int_req(int_req), .vec_num(vec_num), .vec_addr(vec_addr),
  .cur_level(cur_level), .win_lvl_q(win_lvl_q)
);

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
  localparam int PERIOD = 10;
  localparam int NT = 2;
  localparam int NI = 6;
  localparam int TOT = NT + NI;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NT-1:0]   trap_req = '0;
  logic [NI-1:0]   irq_req = '0;
  logic [NI-1:0]   irq_en = '1;
  logic [NI*3-1:0] irq_prio = '0;
  logic            alt_sel = 1'b0;
  logic            ack = 1'b0;
  logic            reti = 1'b0;
  logic            int_req;
  logic [6:0]      vec_num;
  logic [23:0]     vec_addr;
  logic [3:0]      cur_level;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  pvic_top #(.N_TRAP(NT), .N_IRQ(NI), .STACK_DEPTH(4)) dut (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .irq_req(irq_req),
    .irq_en(irq_en), .irq_prio(irq_prio), .alt_sel(alt_sel), .ack(ack),
    .reti(reti), .int_req(int_req), .vec_num(vec_num), .vec_addr(vec_addr),
    .cur_level(cur_level)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input bit alt, input int v);
    return (alt ? 4 + 2 * TOT : 4) + 2 * v;
  endfunction

  task automatic expect_offer(input string req, input int v, input bit alt);
    chk(int_req === 1'b1, req, int'(int_req), 1);
    chk(int'(vec_num) == v, req, int'(vec_num), v);
    chk(int'(vec_addr) == exp_addr(alt, v), req, int'(vec_addr), exp_addr(alt, v));
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Pulse for one edge; outputs are checked two negedges later (R8).
  task automatic pulse(input logic [NT-1:0] t, input logic [NI-1:0] i);
    trap_req = t; irq_req = i;
    tick();
    trap_req = '0; irq_req = '0;
    chk(int_req === 1'b0, "R8 early", int'(int_req), 0);
    tick();
  endtask

  task automatic do_ack();
    ack = 1'b1; tick(); ack = 1'b0;
    chk(int_req === 1'b0, "R9 drop", int'(int_req), 0);
    tick();
  endtask

  task automatic do_reti();
    reti = 1'b1; tick(); reti = 1'b0; tick();
  endtask

  task automatic setp(input int i, input int p);
    irq_prio[i*3 +: 3] = 3'(p);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(int_req === 1'b0 && cur_level == 0 && vec_num == 0 && vec_addr == 0, "R1 in reset", int'(int_req), 0);
    rst_n = 1'b1;
    tick(); tick();
    chk(int_req === 1'b0 && cur_level == 0 && vec_num == 0 && vec_addr == 0, "R1 after reset", int'(cur_level), 0);

    // Traps alone, both tables (R2, R3, R6, R9, R10)
    for (int t = 0; t < NT; t++) begin
      for (int a = 0; a < 2; a++) begin
        alt_sel = a[0];
        pulse(NT'(1 << t), '0);
        expect_offer("R2 R3 trap", t, a[0]);
        do_ack();
        chk(int'(cur_level) == 15 - t, "R9 trap level", int'(cur_level), 15 - t);
        do_reti();
        chk(cur_level == 0, "R10 pop", int'(cur_level), 0);
      end
    end

    // Each maskable source alone at every priority (R2, R3, R4, R5)
    for (int i = 0; i < NI; i++) begin
      for (int p = 0; p < 8; p++) begin
        for (int a = 0; a < 2; a++) begin
          alt_sel = a[0];
          irq_prio = '0; setp(i, p);
          pulse('0, NI'(1 << i));
          if (p == 0) begin
            chk(int_req === 1'b0, "R4 prio zero", int'(int_req), 0);
            setp(i, 1); tick();
            expect_offer("R4 kept pending", NT + i, a[0]);
            do_ack();
          end else begin
            expect_offer("R2 R3 irq", NT + i, a[0]);
            do_ack();
            chk(int'(cur_level) == p, "R9 irq level", int'(cur_level), p);
          end
          do_reti();
        end
      end
    end

    // Enable gating (R4)
    alt_sel = 1'b0; irq_prio = '0; setp(3, 5); irq_en = '0;
    pulse('0, NI'(1 << 3));
    tick();
    chk(int_req === 1'b0, "R4 disabled", int'(int_req), 0);
    irq_en = '1; tick();
    expect_offer("R4 enabled later", NT + 3, 1'b0);
    do_ack(); do_reti();

    // Pairs with ties (R5, R7, R10)
    for (int i = 0; i < NI; i++) begin
      for (int j = i + 1; j < NI; j++) begin
        int pi, pj, w, l, pw;
        pi = ((i + j) % 3) + 4;
        pj = ((i * j) % 3) + 4;
        alt_sel = ((i + j) % 2) == 1;
        irq_prio = '0; setp(i, pi); setp(j, pj);
        if (pi * 16 + (15 - i) > pj * 16 + (15 - j)) begin w = i; l = j; pw = pi; end
        else begin w = j; l = i; pw = pj; end
        pulse('0, NI'((1 << i) | (1 << j)));
        expect_offer("R5 pair winner", NT + w, alt_sel);
        do_ack();
        chk(int'(cur_level) == pw, "R9 pair level", int'(cur_level), pw);
        chk(int_req === 1'b0, "R7 loser masked", int'(int_req), 0);
        do_reti();
        expect_offer("R5 loser after return", NT + l, alt_sel);
        do_ack(); do_reti();
      end
    end

    // Nesting, equal-level masking, trap override, stack unwind (R6, R7, R10)
    alt_sel = 1'b0; irq_prio = '0; setp(0, 3); setp(1, 6); setp(2, 3);
    pulse('0, NI'(1)); expect_offer("R7 first", NT, 1'b0); do_ack();
    pulse('0, NI'(1 << 2));
    chk(int_req === 1'b0, "R7 equal level blocked", int'(int_req), 0);
    pulse('0, NI'(1 << 1)); expect_offer("R7 nested higher", NT + 1, 1'b0); do_ack();
    pulse(NT'(1), '0); expect_offer("R6 trap over level 6", 0, 1'b0); do_ack();
    chk(cur_level == 15, "R9 trap0 level", int'(cur_level), 15);
    pulse(NT'(2), '0); expect_offer("R6 trap under level 15", 1, 1'b0); do_ack();
    chk(cur_level == 14, "R6 trap1 level", int'(cur_level), 14);
    do_reti(); chk(cur_level == 15, "R10 unwind 15", int'(cur_level), 15);
    do_reti(); chk(cur_level == 6, "R10 unwind 6", int'(cur_level), 6);
    do_reti(); chk(cur_level == 3, "R10 unwind 3", int'(cur_level), 3);
    do_reti(); chk(cur_level == 0, "R10 unwind 0", int'(cur_level), 0);
    expect_offer("R7 blocked one released", NT + 2, 1'b0);
    do_ack(); do_reti(); do_reti();
    chk(cur_level == 0, "R10 empty stack", int'(cur_level), 0);

    // Trap against top maskable priority (R6)
    irq_prio = '0; setp(5, 7);
    pulse(NT'(2), NI'(1 << 5));
    expect_offer("R6 trap beats prio 7", 1, 1'b0);
    do_ack();
    chk(int_req === 1'b0, "R6 irq below trap", int'(int_req), 0);
    do_reti();
    expect_offer("R6 irq after trap", NT + 5, 1'b0);
    do_ack(); do_reti();

    // Held line re-asserts through acknowledge (R11)
    irq_prio = '0; setp(4, 2);
    irq_req = NI'(1 << 4);
    tick(); tick();
    expect_offer("R11 held offered", NT + 4, 1'b0);
    do_ack(); do_reti();
    expect_offer("R11 re-asserted", NT + 4, 1'b0);
    irq_req = '0;
    do_ack(); do_reti();
    chk(int_req === 1'b0, "R11 released", int'(int_req), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule